// File: doc/BRIEF.md
# Counted Burst Step Sequencer

This block issues a fixed-length burst of clock-enable pulses each time it is started. It steps an iterative N-bit shift-and-add multiplier or a restoring divider, which needs 2N steps for one result. A start request sets a run latch. While the latch is set, the block raises its step enable on every system clock cycle. The burst is counted by an N-stage twisted-ring (Johnson) register, which passes through 2N states before it returns to all zeros.

No binary count is decoded to find the end of the burst. A divide-by-two toggle watches the last ring stage. The first change of that stage is its rise, and the toggle sets. The second change is its fall, and the toggle is already set, so that fall ends the burst. On the end event the run latch clears, and the ring and the toggle are back at zero. A single-cycle done strobe follows.

Top module: `burst_pulser`

## Requirements
- R1: While reset is high and on the cycle after a synchronous reset, `stepEn`, `busy` and `done` are all 0.
- R2: If `start` is sampled high on a clock edge while `busy` is 0, `busy` and `stepEn` are 1 from that edge on.
- R3: Each burst holds `stepEn` high for exactly 2×STAGES consecutive cycles: 32 with the default STAGES of 16.
- R4: `done` is high for exactly one cycle, and that cycle comes straight after the last pulse of a burst. In that cycle `busy` is already 0.
- R5: A `start` sampled while `busy` is 1 is ignored. It neither lengthens the running burst nor queues a new one, so the cycle after `done` is idle.
- R6: A `start` sampled in the `done` cycle begins a new full-length burst immediately, with no extra idle cycle.
- R7: `stepEn` equals `busy` on every cycle, and `done` never coincides with `stepEn`.
- R8: A reset raised in the middle of a burst stops it at once. No `done` follows, and the next start gives a full-length burst.
- R9: With `start` held high, bursts repeat with a period of 2×STAGES+1 cycles: 2×STAGES busy cycles, then one idle cycle carrying `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Burst request, sampled on each clock edge |
| stepEn | output | 1 | Step enable for the arithmetic datapath, one per cycle during a burst |
| busy | output | 1 | Run latch state: a burst is in progress |
| done | output | 1 | One-cycle strobe after the last step enable |

## Verification
A ring that skips or repeats a state, or a toggle that starts set, changes the length of the burst. The change shows at `done` at the end of the first burst after start, so counting step enables per burst exposes it within 2×STAGES+1 cycles. A run latch that accepts a start while busy would show as an extra burst right after `done`. A toggle left dirty after reset shows as a short burst after a mid-burst reset. The bench sweeps a mid-burst start over every pulse position and checks continuous restart patterns against periods computed from STAGES.

// File: rtl/burst_pulser_pkg.sv
package burst_pulser_pkg;
  // Strobes from the control module to the counting datapath
  typedef struct packed {
    logic clearRing; // zero the ring and the end-detect toggle
    logic advance;   // step the ring by one state
  } seqStrobe_t;
endpackage

// File: rtl/burst_ring.sv
module burst_ring
  import burst_pulser_pkg::*;
#(
  parameter int STAGES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t strobe,
  output logic       burstEnd
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] ringQ;
  logic [LAST:0] ringD;
  logic          toggleQ;
  logic          lastEdge;

  // Twisted-ring next state: shift toward the last stage, feed the inverted last stage back in
  generate
    if (STAGES == 1) begin : g_single
      assign ringD = ~ringQ;
    end else begin : g_chain
      assign ringD = {ringQ[LAST-1:0], ~ringQ[LAST]};
    end
  endgenerate

  // A change of the last stage on this step: its first change is a rise, its second a fall
  assign lastEdge = strobe.advance && (ringD[LAST] != ringQ[LAST]);
  // The toggle is already set when the falling change arrives, so that change ends the burst
  assign burstEnd = lastEdge && toggleQ;

  always_ff @(posedge clk) begin
    if (rst || strobe.clearRing) begin
      ringQ   <= '0;
      toggleQ <= 1'b0;
    end else begin
      if (strobe.advance) ringQ <= ringD;
      if (lastEdge)       toggleQ <= ~toggleQ;
    end
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pulser_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       burstEnd,
  output seqStrobe_t strobe,
  output logic       runQ,
  output logic       doneQ
);
  logic startAccept;

  // Requests are only taken while the run latch is clear
  assign startAccept     = start && !runQ;
  assign strobe.clearRing = startAccept;
  assign strobe.advance   = runQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      runQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      if (startAccept)   runQ <= 1'b1;
      else if (burstEnd) runQ <= 1'b0;
      doneQ <= burstEnd;
    end
  end
endmodule

// File: rtl/burst_pulser.sv
module burst_pulser
  import burst_pulser_pkg::*;
#(
  parameter int STAGES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic stepEn,
  output logic busy,
  output logic done
);
  seqStrobe_t strobe;
  logic       burstEnd;
  logic       runQ;
  logic       doneQ;

  burst_ctrl ctrlInst (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .burstEnd(burstEnd),
    .strobe  (strobe),
    .runQ    (runQ),
    .doneQ   (doneQ)
  );

  burst_ring #(.STAGES(STAGES)) ringInst (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .burstEnd(burstEnd)
  );

  assign stepEn = runQ;
  assign busy   = runQ;
  assign done   = doneQ;
endmodule

// File: rtl/burst_pulser_chk.sv
module burst_pulser_chk #(
  parameter int STAGES = 16
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic stepEn,
  input logic busy,
  input logic done
);
  localparam int PULSES = 2 * STAGES;
  localparam int CW     = $clog2(PULSES + 1) + 1;

  // Number of busy cycles seen so far in the current run
  logic [CW-1:0] runCnt;
  always_ff @(posedge clk) begin
    if (rst)       runCnt <= '0;
    else if (busy) runCnt <= runCnt + 1'b1;
    else           runCnt <= '0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> (!busy && !done && !stepEn));
  assert_start_taken_R2: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
  assert_no_long_burst_R3: assert property (@(posedge clk) disable iff (rst) busy |-> (runCnt < CW'(PULSES)));
  assert_exact_burst_R3: assert property (@(posedge clk) disable iff (rst) done |-> (runCnt == CW'(PULSES)));
  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy)));
  assert_no_early_stop_R5: assert property (@(posedge clk) disable iff (rst) (busy && runCnt < CW'(PULSES - 1)) |=> busy);
  assert_done_not_step_R7: assert property (@(posedge clk) disable iff (rst) done |-> !stepEn);
endmodule

bind burst_pulser burst_pulser_chk #(.STAGES(STAGES)) chkInst (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .stepEn(stepEn),
  .busy  (busy),
  .done  (done)
);

// File: tb/burst_pulser_test.sv
module burst_pulser_test;
  localparam int STAGES = 16;
  localparam int PULSES = 2 * STAGES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic stepEn, busy, done;
  int   total = 0;
  int   bad = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  burst_pulser #(.STAGES(STAGES)) uut (
    .clk(clk), .rst(rst), .start(start),
    .stepEn(stepEn), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive inputs at the falling edge, sample just after the next rising edge
  task automatic step(input logic s, input logic r);
    @(negedge clk);
    start = s;
    rst   = r;
    @(posedge clk);
    #1;
  endtask

  // Runs one burst from an idle or done cycle; midAt >= 0 pulses start again at that pulse index
  task automatic runBurst(input int midAt, input string req);
    int pulses = 0;
    int guard = 0;
    step(1'b1, 1'b0);
    chk(busy && stepEn, "R2 busy after start", busy, 1);
    while (busy && guard < 4 * PULSES) begin
      pulses++;
      chk(stepEn == busy, "R7 stepEn equals busy", stepEn, busy);
      step((pulses - 1) == midAt, 1'b0);
      guard++;
    end
    chk(pulses == PULSES, {req, " burst length"}, pulses, PULSES);
    chk(done && !busy, "R4 done with busy low", done, 1);
    chk(!(done && stepEn), "R7 done without stepEn", stepEn, 0);
  endtask

  initial begin
    step(1'b0, 1'b1);
    chk(!busy && !done && !stepEn, "R1 idle in reset", {busy, done, stepEn}, 0);
    step(1'b0, 1'b0);
    chk(!busy && !done && !stepEn, "R1 idle after reset", {busy, done, stepEn}, 0);
    step(1'b0, 1'b0);
    chk(!busy, "R1 stays idle without start", busy, 0);

    // Plain burst, then single-cycle done
    runBurst(-1, "R3");
    step(1'b0, 1'b0);
    chk(!done, "R4 done lasts one cycle", done, 0);
    chk(!busy, "R4 idle after done", busy, 0);

    // Sweep a start request over every pulse position of a burst
    for (int off = 0; off < PULSES; off++) begin
      runBurst(off, "R5");
      step(1'b0, 1'b0);
      chk(!busy && !done, "R5 mid-burst start not queued", busy, 0);
    end

    // Back-to-back: start in the done cycle
    runBurst(-1, "R6");
    runBurst(-1, "R6");
    runBurst(-1, "R6");
    step(1'b0, 1'b0);
    chk(!busy, "R6 idle after chain", busy, 0);

    // Start held high: period PULSES+1
    for (int k = 1; k <= 3 * (PULSES + 1); k++) begin
      step(1'b1, 1'b0);
      chk(busy == (((k - 1) % (PULSES + 1)) != PULSES), "R9 held start pattern", busy,
          (((k - 1) % (PULSES + 1)) != PULSES));
      chk(done == (((k - 1) % (PULSES + 1)) == PULSES), "R9 held start done", done,
          (((k - 1) % (PULSES + 1)) == PULSES));
    end
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);

    // Reset in the middle of a burst
    step(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    chk(!busy && !done, "R8 reset stops burst", busy, 0);
    for (int i = 0; i < PULSES + 3; i++) begin
      step(1'b0, 1'b0);
      chk(!busy && !done, "R8 no done after reset", done, 0);
    end
    runBurst(-1, "R8");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule